// File: doc/BRIEF.md
# Spread-Spectrum Triangle Profile Generator

This block produces the digital frequency-offset profile that a downstream numerically controlled clock, or a phase-stepping stage, uses to spread the energy of an output pixel clock. It runs on the pixel clock itself. A 4-bit select code picks two things at once: a modulation period, counted in pixel-clock cycles, and a peak deviation. The block then emits a signed offset word in parts per 10,000 that traces a symmetric triangle around zero, along with a flag that reports whether spreading is active.

The triangle starts at zero, rises to the positive peak, falls through zero to the negative peak and climbs back to zero, once per modulation period. The output is the exact truncated quotient of that triangle, computed with an incremental remainder, so it never moves by more than one unit per cycle. The block accepts a new select code only at a zero point of the profile. This keeps the offset free of jumps when software changes the setting while the clock is running.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the offset is 0 and the enable flag is low. The reset state is the "spreading off" setting.
- R2: When the active code is 0000, the offset stays at 0 and the enable flag stays low on every cycle.
- R3: The modulation period in clock cycles depends on the code. Codes 1–4 give 2168, codes 5–8 give 1300, codes 9–12 give 868 and codes 13–15 give 650. The period is measured between successive 0 to +1 transitions of the offset.
- R4: The deviation depth is ((code−1) mod 4 + 1) × 50 parts per 10,000, giving 50, 100, 150 and 200 within each group. Codes 13–15 have only 50, 100 and 150. The largest offset magnitude over a period equals the depth when the period is a multiple of 4. Otherwise it equals floor(depth × (period−2) / period).
- R5: With period D, depth V and phase p (0 ≤ p < D), let a = 4p if 4p ≤ D; a = 2D − 4p if D < 4p < 3D; and a = 4p − 4D otherwise. The offset is the sign of a times floor(V·|a| / D), in two's complement.
- R6: Between any two consecutive cycles the offset changes by at most one unit.
- R7: The select input is taken only on a cycle where the profile is at a zero point (a = 0), or when spreading is off. At phase 0, or on a start from off, the new setting begins at phase 1 (the rising half). At the mid-period zero it begins at phase D'/2 + 1 of the new period D' (the falling, negative half). Before this, the phase just advances, wrapping from D−1 to 0.
- R8: The magnitude of the offset never exceeds the depth of the active code.
- R9: The enable flag is high exactly when the active code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ssc_sel_i | input | 4 | Select code: 0 = off, 1–15 = period group and depth |
| ofs_o | output | OFS_W | Signed frequency offset, parts per 10,000 |
| spread_en_o | output | 1 | High while a nonzero code is active |

## Verification
Several properties are checked on every clock cycle. One is the single-unit step limit on the offset. Another is the bound of the offset by the active depth. A third is that the offset is zero whenever the flag is low. The last is that the active setting changes only after a cycle whose offset was zero, and that the phase stays inside the active period.

The exact triangle values, the period of each group and the peak of each depth can only be shown by running the bench's scenarios. The same holds for the deferral of a code change from mid-ramp to the next zero point, and for the entry into the negative half when the change lands at mid-period. The bench shows these by comparing the output on every cycle with a division-based model, and by measuring the peaks and periods over windows of steady operation.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

   localparam int CODE_W = 4;

   typedef logic [CODE_W-1:0] ssc_code_t;

   // direction of the triangle magnitude between two consecutive phases
   typedef enum logic [1:0] {
      MAG_HOLD = 2'd0,
      MAG_UP   = 2'd1,
      MAG_DOWN = 2'd2
   } mag_dir_e;

   // zero-based slot of a nonzero code: bits [3:2] pick the period group,
   // bits [1:0] pick the depth step
   function automatic ssc_code_t code_slot(input ssc_code_t code);
      return code - ssc_code_t'(1);
   endfunction

endpackage

// File: rtl/ssc_code_decode.sv
module ssc_code_decode
   import ssc_pkg::*;
#(
   parameter int DIV_W    = 12,
   parameter int DEV_W    = 8,
   parameter int DIV_A    = 2168,
   parameter int DIV_B    = 1300,
   parameter int DIV_C    = 868,
   parameter int DIV_D    = 650,
   parameter int DEV_STEP = 50
) (
   input  ssc_code_t        code_i,
   output logic [DIV_W-1:0] div_o,
   output logic [DEV_W-1:0] dev_o,
   output logic             on_o
);

   localparam int N_GRP = 4;
   localparam int DIV_TAB [N_GRP] = '{DIV_A, DIV_B, DIV_C, DIV_D};

   ssc_code_t        slot;
   logic [1:0]       grp;
   logic [1:0]       depth;
   logic [DIV_W-1:0] div_cand [N_GRP];

   assign on_o  = (code_i != '0);
   assign slot  = code_slot(code_i);
   assign grp   = slot[3:2];
   assign depth = slot[1:0];

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      assign div_cand[g] = (on_o && (grp == 2'(g))) ? DIV_W'(DIV_TAB[g]) : '0;
   end

   always_comb begin
      div_o = '0;
      for (int g = 0; g < N_GRP; g++) begin
         div_o = div_o | div_cand[g];
      end
   end

   assign dev_o = on_o ? DEV_W'(DEV_STEP * (int'(depth) + 1)) : '0;

endmodule

// File: rtl/ssc_phase_ctrl.sv
module ssc_phase_ctrl
   import ssc_pkg::*;
#(
   parameter int DIV_W = 12,
   parameter int DEV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  ssc_code_t        sel_code_i,
   input  logic [DIV_W-1:0] sel_div_i,
   input  logic [DEV_W-1:0] sel_dev_i,
   output ssc_code_t        code_o,
   output logic [DEV_W-1:0] dev_o,
   output logic [DIV_W-1:0] nx_div_o,
   output logic [DEV_W-1:0] nx_dev_o,
   output logic             nx_off_o,
   output logic             nx_neg_o,
   output mag_dir_e         dir_o
);

   // signed triangle sample on a 4x phase grid, returned as {sign, magnitude}
   function automatic logic [DIV_W:0] tri_point(input logic [DIV_W-1:0] p,
                                                input logic [DIV_W-1:0] d);
      int p4;
      int dd;
      int v;
      p4 = 4 * int'(p);
      dd = int'(d);
      if (p4 <= dd)          v = p4;
      else if (p4 < 3 * dd)  v = 2 * dd - p4;
      else                   v = p4 - 4 * dd;
      return (v < 0) ? {1'b1, DIV_W'(-v)} : {1'b0, DIV_W'(v)};
   endfunction

   ssc_code_t        code_q, code_n;
   logic [DIV_W-1:0] div_q, div_n;
   logic [DEV_W-1:0] dev_q, dev_n;
   logic [DIV_W-1:0] p_q, p_n;
   logic [DIV_W-1:0] abs_q, abs_n;
   logic             neg_n;
   logic             at_zero;

   always_comb begin
      at_zero = (code_q == '0) || (abs_q == '0);
      code_n  = code_q;
      div_n   = div_q;
      dev_n   = dev_q;
      if (at_zero) begin
         code_n = sel_code_i;
         div_n  = sel_div_i;
         dev_n  = sel_dev_i;
         if (sel_code_i == '0)
            p_n = '0;
         else if ((code_q != '0) && (p_q != '0))
            p_n = (sel_div_i >> 1) + DIV_W'(1);
         else
            p_n = DIV_W'(1);
      end else begin
         p_n = (p_q == div_q - DIV_W'(1)) ? '0 : p_q + DIV_W'(1);
      end
      {neg_n, abs_n} = tri_point(p_n, div_n);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_q <= '0;
         div_q  <= '0;
         dev_q  <= '0;
         p_q    <= '0;
         abs_q  <= '0;
      end else begin
         code_q <= code_n;
         div_q  <= div_n;
         dev_q  <= dev_n;
         p_q    <= p_n;
         abs_q  <= abs_n;
      end
   end

   always_comb begin
      if (abs_n > abs_q)      dir_o = MAG_UP;
      else if (abs_n < abs_q) dir_o = MAG_DOWN;
      else                    dir_o = MAG_HOLD;
   end

   assign code_o   = code_q;
   assign dev_o    = dev_q;
   assign nx_div_o = div_n;
   assign nx_dev_o = dev_n;
   assign nx_off_o = (code_n == '0);
   assign nx_neg_o = neg_n;

   // the phase stays inside the active modulation period
   assert_phase_in_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_q != '0) |-> (p_q < div_q));

endmodule

// File: rtl/ssc_mag_track.sv
module ssc_mag_track
   import ssc_pkg::*;
#(
   parameter int DIV_W = 12,
   parameter int DEV_W = 8,
   parameter int OFS_W = 10
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  mag_dir_e                dir_i,
   input  logic                    neg_i,
   input  logic                    off_i,
   input  logic [DIV_W-1:0]        div_i,
   input  logic [DEV_W-1:0]        dev_i,
   output logic signed [OFS_W-1:0] ofs_o
);

   localparam int RW = ((DIV_W > DEV_W + 2) ? DIV_W : DEV_W + 2) + 1;

   logic [RW-1:0]          rem_q;
   logic [RW-1:0]          step_w;
   logic [RW-1:0]          div_w;
   logic [RW-1:0]          sum_w;
   logic [DEV_W-1:0]       quo_q;
   logic                   neg_q;
   logic signed [OFS_W-1:0] mag_s;

   // each phase moves |a| by 4, so the scaled numerator moves by 4*depth
   assign step_w = RW'({dev_i, 2'b00});
   assign div_w  = RW'(div_i);
   assign sum_w  = rem_q + step_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rem_q <= '0;
         quo_q <= '0;
         neg_q <= 1'b0;
      end else if (off_i) begin
         rem_q <= '0;
         quo_q <= '0;
         neg_q <= 1'b0;
      end else begin
         neg_q <= neg_i;
         unique case (dir_i)
            MAG_UP: begin
               if (sum_w >= div_w) begin
                  quo_q <= quo_q + DEV_W'(1);
                  rem_q <= sum_w - div_w;
               end else begin
                  rem_q <= sum_w;
               end
            end
            MAG_DOWN: begin
               if (rem_q >= step_w) begin
                  rem_q <= rem_q - step_w;
               end else begin
                  rem_q <= rem_q + div_w - step_w;
                  quo_q <= quo_q - DEV_W'(1);
               end
            end
            default: ;
         endcase
      end
   end

   assign mag_s = OFS_W'(quo_q);
   assign ofs_o = neg_q ? -mag_s : mag_s;

   // the profile never jumps: one unit per cycle at most
   assert_unit_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((int'(ofs_o) - int'($past(ofs_o)) <= 1) &&
       (int'(ofs_o) - int'($past(ofs_o)) >= -1)));

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
   import ssc_pkg::*;
#(
   parameter int DIV_W    = 12,
   parameter int DEV_W    = 8,
   parameter int OFS_W    = 10,
   parameter int DIV_A    = 2168,
   parameter int DIV_B    = 1300,
   parameter int DIV_C    = 868,
   parameter int DIV_D    = 650,
   parameter int DEV_STEP = 50
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [3:0]              ssc_sel_i,
   output logic signed [OFS_W-1:0] ofs_o,
   output logic                    spread_en_o
);

   localparam int DIV_MAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
   localparam int DEV_MAX = 4 * DEV_STEP;

   // elaboration-time parameter checks
   if (DIV_MAX >= (1 << DIV_W) || DIV_C >= (1 << DIV_W) || DIV_D >= (1 << DIV_W))
   begin : g_chk_div_w
      $error("ssc_profile_gen: a period does not fit DIV_W");
   end
   if ((DIV_A % 2) || (DIV_B % 2) || (DIV_C % 2) || (DIV_D % 2)) begin : g_chk_even
      $error("ssc_profile_gen: periods must be even");
   end
   if ((4 * DEV_MAX >= DIV_A) || (4 * DEV_MAX >= DIV_B) || (4 * DEV_MAX >= DIV_C) ||
       (12 * DEV_STEP >= DIV_D)) begin : g_chk_slope
      $error("ssc_profile_gen: depth too steep for one unit per cycle");
   end
   if ((DEV_MAX >= (1 << DEV_W)) || (OFS_W <= DEV_W)) begin : g_chk_dev_w
      $error("ssc_profile_gen: depth or offset width too small");
   end

   ssc_code_t        sel_code;
   logic [DIV_W-1:0] sel_div;
   logic [DEV_W-1:0] sel_dev;
   logic             sel_on;
   ssc_code_t        code_act;
   logic [DEV_W-1:0] dev_act;
   logic [DIV_W-1:0] nx_div;
   logic [DEV_W-1:0] nx_dev;
   logic             nx_off;
   logic             nx_neg;
   mag_dir_e         dir;

   assign sel_code = ssc_sel_i;

   ssc_code_decode #(
      .DIV_W(DIV_W), .DEV_W(DEV_W),
      .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .DIV_D(DIV_D),
      .DEV_STEP(DEV_STEP)
   ) u_decode (
      .code_i (sel_code),
      .div_o  (sel_div),
      .dev_o  (sel_dev),
      .on_o   (sel_on)
   );

   ssc_phase_ctrl #(.DIV_W(DIV_W), .DEV_W(DEV_W)) u_phase (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_code_i (sel_code),
      .sel_div_i  (sel_div),
      .sel_dev_i  (sel_dev),
      .code_o     (code_act),
      .dev_o      (dev_act),
      .nx_div_o   (nx_div),
      .nx_dev_o   (nx_dev),
      .nx_off_o   (nx_off),
      .nx_neg_o   (nx_neg),
      .dir_o      (dir)
   );

   ssc_mag_track #(.DIV_W(DIV_W), .DEV_W(DEV_W), .OFS_W(OFS_W)) u_mag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .dir_i  (dir),
      .neg_i  (nx_neg),
      .off_i  (nx_off),
      .div_i  (nx_div),
      .dev_i  (nx_dev),
      .ofs_o  (ofs_o)
   );

   assign spread_en_o = (code_act != '0);

   // a new setting is adopted only right after a zero-valued cycle
   assert_switch_at_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(code_act) |-> ($past(ofs_o) == '0));

   // magnitude bounded by the active depth
   assert_within_depth_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(ofs_o) <= int'(dev_act)) && (int'(ofs_o) >= -int'(dev_act)));

   // flag low means a flat zero output
   assert_off_is_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !spread_en_o |-> (ofs_o == '0));

   // the decoder's "on" agrees with a nonzero select
   always_comb begin
      assert_decode_on_R9: assert (sel_on == (sel_code != '0));
   end

endmodule

// File: tb/ssc_profile_gen_tb.sv
module ssc_profile_gen_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [3:0]        sel = 4'd0;
   logic signed [9:0] ofs;
   logic              en;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ssc_profile_gen dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ssc_sel_i   (sel),
      .ofs_o       (ofs),
      .spread_en_o (en)
   );

   // ---------------- requirement-level helpers ----------------
   function automatic int div_of(input int c);
      if (c == 0) return 0;
      if (c <= 4) return 2168;
      if (c <= 8) return 1300;
      if (c <= 12) return 868;
      return 650;
   endfunction

   function automatic int dev_of(input int c);
      if (c == 0) return 0;
      return 50 * (((c - 1) % 4) + 1);
   endfunction

   function automatic int a_of(input int p, input int d);
      if (4 * p <= d) return 4 * p;
      if (4 * p < 3 * d) return 2 * d - 4 * p;
      return 4 * p - 4 * d;
   endfunction

   function automatic int peak_of(input int c);
      int d;
      d = div_of(c);
      if (d % 4 == 0) return dev_of(c);
      return (dev_of(c) * (d - 2)) / d;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_code = 0;
   int m_p    = 0;
   int m_ofs  = 0;
   bit m_en   = 1'b0;

   always @(posedge clk) begin
      int d;
      int a;
      int mag;
      int nc;
      if (!rst_n) begin
         m_code = 0; m_p = 0; m_ofs = 0; m_en = 1'b0;
      end else begin
         d = div_of(m_code);
         a = (m_code == 0) ? 0 : a_of(m_p, d);
         if (a == 0) begin
            nc = int'(sel);
            if (nc == 0) m_p = 0;
            else if (m_code != 0 && m_p != 0) m_p = div_of(nc) / 2 + 1;
            else m_p = 1;
            m_code = nc;
         end else begin
            m_p = (m_p + 1) % d;
         end
         d = div_of(m_code);
         if (m_code == 0) begin
            m_ofs = 0;
         end else begin
            a = a_of(m_p, d);
            mag = (dev_of(m_code) * ((a < 0) ? -a : a)) / d;
            m_ofs = (a < 0) ? -mag : mag;
         end
         m_en = (m_code != 0);
      end
   end

   // ---------------- per-cycle comparison and window statistics ----------------
   bit cmp_on   = 1'b0;
   bit win_on   = 1'b0;
   int n_cyc    = 0;
   int prev_ofs = 0;
   int win_peak = 0;
   int win_last = -1;
   int win_gap  = -1;

   always @(negedge clk) begin
      n_cyc++;
      if (rst_n && cmp_on) begin
         chk(int'(ofs) == m_ofs, "R5 offset", int'(ofs), m_ofs);
         chk(en == m_en, "R9 enable", int'(en), int'(m_en));
         if (win_on) begin
            if (((int'(ofs) < 0) ? -int'(ofs) : int'(ofs)) > win_peak)
               win_peak = (int'(ofs) < 0) ? -int'(ofs) : int'(ofs);
            if (prev_ofs == 0 && int'(ofs) == 1) begin
               if (win_last >= 0 && win_gap < 0) win_gap = n_cyc - win_last;
               win_last = n_cyc;
            end
         end
      end
      prev_ofs = int'(ofs);
   end

   task automatic run_code(input int c);
      @(negedge clk);
      sel = 4'(c);
      repeat (2200) @(negedge clk);
      win_peak = 0; win_last = -1; win_gap = -1; win_on = 1'b1;
      repeat (2 * div_of(c) + 4) @(negedge clk);
      win_on = 1'b0;
      chk(win_peak == peak_of(c), "R4 peak", win_peak, peak_of(c));
      chk(win_gap == div_of(c), "R3 period", win_gap, div_of(c));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * WATCHDOG);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // ---------------- scenarios ----------------
   initial begin
      int hold_ofs;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(ofs == '0, "R1 offset in reset", int'(ofs), 0);
      chk(en == 1'b0, "R1 enable in reset", int'(en), 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      @(negedge clk);
      chk(ofs == '0, "R1 offset after release", int'(ofs), 0);
      chk(en == 1'b0, "R1 enable after release", int'(en), 0);

      // R2: off code holds zero
      repeat (40) @(negedge clk);
      chk(ofs == '0 && en == 1'b0, "R2 off state", int'(ofs), 0);

      // R3, R4, R5: every code in steady operation
      for (int c = 1; c <= 15; c++) begin
         run_code(c);
      end

      // R7: change during a rising ramp is deferred
      sel = 4'd0;
      repeat (1200) @(negedge clk);
      chk(en == 1'b0, "R2 back to off", int'(en), 0);
      sel = 4'd1;
      repeat (300) @(negedge clk);
      hold_ofs = int'(ofs);
      sel = 4'd13;
      @(negedge clk);
      chk(int'(ofs) >= hold_ofs && ofs != '0, "R7 ramp continues", int'(ofs), hold_ofs);
      repeat (2500) @(negedge clk);

      // R7: off request in the middle of a half waits for the zero point
      sel = 4'd7;
      repeat (700) @(negedge clk);
      sel = 4'd0;
      @(negedge clk);
      chk(en == 1'b1, "R7 off deferred", int'(en), 1);
      repeat (1400) @(negedge clk);
      chk(en == 1'b0 && ofs == '0, "R2 off reached", int'(en), 0);

      // R7: switch landing at the mid-period zero enters the negative half
      sel = 4'd9;
      repeat (500) @(negedge clk);
      sel = 4'd4;
      repeat (1500) @(negedge clk);

      // R1: reset in mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk(ofs == '0 && en == 1'b0, "R1 mid-run reset", int'(ofs), 0);
      sel = 4'd0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(ofs == '0 && en == 1'b0, "R1 after mid-run reset", int'(ofs), 0);

      cmp_on = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule